// File: doc/BRIEF.md
# Two-Wire Status and Shutdown Register Slave

This block is a slave on a two-wire serial bus of the I2C/SMBus kind. It sits in a power-sequencing controller and gives a host two registers. The status register can only be read. It reports the three gate-enable states that the sequencer supplies, and it also holds a write-enable latch. The shutdown register is two bits wide. Its value goes straight to the sequencer as a shutdown mode selector.

SCL and SDA are oversampled by the system clock through two-stage synchronizers. START and STOP conditions are found from the synchronized samples. The slave pulls SDA low through an output-enable pin; it never drives SDA high. It accepts byte writes. It also serves random reads: the host writes the word address, sends a repeated START, and reads one byte. Writes to the shutdown register are accepted only while the write-enable latch is set. A write that is refused is answered by withholding the acknowledge on the data byte.

Top module: `twsr_slave`

## Requirements
- R1: After reset, `shut_mode` is 0 and `sda_oe` is 0. The write-enable latch is 0, so status bit 0 reads 0 and the shutdown register reads 00h.
- R2: The address byte is bits 7..4 = 1010, bits 3..1 = `dev_sel`, and bit 0 = R/W (1 = read). It is acknowledged only on a full match. On a mismatch no byte of that transfer is acknowledged and nothing is written.
- R3: Word address 00h reads the status byte. Its bits 7..4 are 0, bit 3 is `gate_stat[2]`, bit 2 is `gate_stat[1]`, bit 1 is `gate_stat[0]`, and bit 0 is the write-enable latch. The status bits follow `gate_stat` at the time of the read, and writes do not change them.
- R4: Writing 01h to word address 00h sets the write-enable latch. Writing 00h to word address 00h clears it. Any other value written there leaves it unchanged.
- R5: While the latch is 0, a data byte written to word address FFh is not acknowledged and `shut_mode` does not change.
- R6: While the latch is 1, a data byte written to word address FFh is acknowledged and `shut_mode` takes data bits 1..0. This happens three clock edges after SCL rises on the eighth data bit. A read of FFh returns `{6'b0, shut_mode}`.
- R7: A random read returns exactly one byte, MSB first, from the last word address written. After the master's no-acknowledge and STOP, SDA is released.
- R8: A write to a word address other than 00h or FFh is acknowledged and changes nothing. A read of such an address returns 00h.
- R9: A START or STOP seen in the middle of a byte abandons that byte. A partly received data byte never reaches a register.
- R10: On a legal bus, the slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock as seen on the bus |
| sda_i | input | 1 | Serial data as seen on the bus (wired-AND) |
| sda_oe | output | 1 | 1 pulls SDA low |
| dev_sel | input | 3 | Strap value compared with address bits 3..1 |
| gate_stat | input | 3 | Gate-enable states {H, M, L} from the sequencer |
| shut_mode | output | 2 | Shutdown mode selector to the sequencer |

## Verification
An SCL edge at the input reaches the registers on the third rising clock edge, after two synchronizer stages and one edge-detect stage. So `shut_mode` changes three edges after SCL rises on the last data bit, and `sda_oe` changes three edges after each SCL fall. The bench holds every SCL phase for eight clocks and samples SDA one clock before SCL falls, well after the slave's drive has settled. The reference model updates its expected shutdown value on exactly the third rising edge after it raises SCL, and it compares against `shut_mode` on every falling edge. The model also tracks the write-enable latch and the expected acknowledges.

// File: rtl/twsr_slave.sv
module twsr_slave #(
  parameter logic [3:0] DEV_TYPE  = 4'b1010,
  parameter logic [7:0] STAT_ADDR = 8'h00,
  parameter logic [7:0] SHUT_ADDR = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] dev_sel,
  input  logic [2:0] gate_stat,
  output logic [1:0] shut_mode
);

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_WORD, S_WDATA, S_ACK, S_TX, S_MACK, S_WAIT
  } state_t;

  logic [1:0] scl_q, sda_q;
  logic       scl_d, sda_d;
  logic       scl_s, sda_s;
  logic       scl_rise, scl_fall, bus_start, bus_stop;

  state_t     st, nxt;
  logic [2:0] bitcnt;
  logic [6:0] sh;
  logic [7:0] tx, waddr, rd_val, rx_byte;
  logic       give_ack, ack_ph, wel, addr_hit;
  logic [1:0] shut;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 2'b11;
      sda_q <= 2'b11;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[0], scl_i};
      sda_q <= {sda_q[0], sda_i};
      scl_d <= scl_q[1];
      sda_d <= sda_q[1];
    end
  end

  assign scl_s     = scl_q[1];
  assign sda_s     = sda_q[1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign bus_start = scl_s & scl_d & sda_d & ~sda_s;
  assign bus_stop  = scl_s & scl_d & ~sda_d & sda_s;

  assign rx_byte   = {sh, sda_s};
  assign addr_hit  = (rx_byte[7:4] == DEV_TYPE) && (rx_byte[3:1] == dev_sel);
  assign shut_mode = shut;

  always_comb begin
    rd_val = 8'h00;
    if (waddr == STAT_ADDR)      rd_val = {4'b0000, gate_stat, wel};
    else if (waddr == SHUT_ADDR) rd_val = {6'b000000, shut};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      nxt      <= S_IDLE;
      bitcnt   <= 3'd0;
      sh       <= 7'd0;
      tx       <= 8'd0;
      waddr    <= 8'd0;
      give_ack <= 1'b0;
      ack_ph   <= 1'b0;
      wel      <= 1'b0;
      shut     <= 2'b00;
      sda_oe   <= 1'b0;
    end else if (bus_start) begin
      st     <= S_ADDR;
      bitcnt <= 3'd0;
      sda_oe <= 1'b0;
    end else if (bus_stop) begin
      st     <= S_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (st)
        S_ADDR, S_WORD, S_WDATA: begin
          if (scl_rise) begin
            sh     <= rx_byte[6:0];
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) begin
              ack_ph <= 1'b0;
              if (st == S_ADDR) begin
                if (addr_hit) begin
                  give_ack <= 1'b1;
                  st       <= S_ACK;
                  nxt      <= rx_byte[0] ? S_TX : S_WORD;
                end else begin
                  st <= S_WAIT;
                end
              end else if (st == S_WORD) begin
                waddr    <= rx_byte;
                give_ack <= 1'b1;
                st       <= S_ACK;
                nxt      <= S_WDATA;
              end else begin
                st       <= S_ACK;
                nxt      <= S_WAIT;
                give_ack <= (waddr != SHUT_ADDR) || wel;
                if (waddr == STAT_ADDR) begin
                  if (rx_byte == 8'h01)      wel <= 1'b1;
                  else if (rx_byte == 8'h00) wel <= 1'b0;
                end else if (waddr == SHUT_ADDR && wel) begin
                  shut <= rx_byte[1:0];
                end
              end
            end
          end
        end
        S_ACK: begin
          if (scl_fall) begin
            if (!ack_ph) begin
              sda_oe <= give_ack;
              ack_ph <= 1'b1;
            end else begin
              st     <= nxt;
              bitcnt <= 3'd0;
              if (nxt == S_TX) begin
                sda_oe <= ~rd_val[7];
                tx     <= {rd_val[6:0], 1'b0};
              end else begin
                sda_oe <= 1'b0;
              end
            end
          end
        end
        S_TX: begin
          if (scl_fall) begin
            sda_oe <= ~tx[7];
            tx     <= {tx[6:0], 1'b0};
          end
          if (scl_rise) begin
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) st <= S_MACK;
          end
        end
        S_MACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            st     <= S_WAIT;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

module twsr_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       scl_d,
  input logic       sda_oe,
  input logic       wel,
  input logic [2:0] st,
  input logic [1:0] shut_mode
);

  AST_SDA_MOVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_s)); // R10

  AST_SHUT_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(shut_mode) |-> $past(wel)); // R5

  AST_SHUT_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(shut_mode) |-> ($past(scl_s) && !$past(scl_d))); // R6

  AST_WEL_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wel) |-> ($past(scl_s) && !$past(scl_d))); // R4

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0) |-> !sda_oe); // R7

endmodule

bind twsr_slave twsr_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_d(scl_d),
  .sda_oe(sda_oe), .wel(wel), .st(st), .shut_mode(shut_mode)
);

// File: tb/twsr_slave_tb.sv
module twsr_slave_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;
  localparam logic [2:0] SEL = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic sda_oe, sda_bus;
  logic [2:0] gate_stat = 3'b101;
  logic [1:0] shut_mode;

  int n_chk = 0, n_bad = 0, r10_viol = 0, scl_hi = 0;
  logic [1:0] exp_shut = 2'b00;
  logic exp_wel = 1'b0;
  logic done = 1'b0;
  logic prev_oe = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  twsr_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .dev_sel(SEL), .gate_stat(gate_stat), .shut_mode(shut_mode)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_chk++;
      if (shut_mode !== exp_shut) begin
        n_bad++;
        $display("FAIL R6 per-clock shut_mode act=%0d exp=%0d", shut_mode, exp_shut);
      end
      scl_hi = scl ? scl_hi + 1 : 0;
      if (scl_hi >= 4 && sda_oe !== prev_oe) r10_viol++;
      prev_oe = sda_oe;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(HALF/2);
    scl = 1'b1;   tick(HALF);
    sda_m = 1'b0; tick(HALF);
    scl = 1'b0;   tick(HALF/2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(HALF/2);
    scl = 1'b1;   tick(HALF);
    sda_m = 1'b1; tick(HALF);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n, input logic apply, input logic [1:0] aval);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; tick(HALF/2);
      scl = 1'b1;
      if (i == 0 && apply) begin
        repeat (3) @(posedge clk);
        exp_shut = aval;
        @(negedge clk);
        tick(HALF-3);
      end else begin
        tick(HALF);
      end
      scl = 1'b0; tick(HALF/2);
    end
  endtask

  task automatic get_ack(output logic a);
    sda_m = 1'b1; tick(HALF/2);
    scl = 1'b1;   tick(HALF-1);
    a = ~sda_bus; tick(1);
    scl = 1'b0;   tick(HALF/2);
  endtask

  task automatic recv_byte(output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(HALF);
      scl = 1'b1; tick(HALF-1);
      b[i] = sda_bus; tick(1);
      scl = 1'b0;
    end
    tick(HALF);
    scl = 1'b1; tick(HALF);
    scl = 1'b0; tick(HALF/2);
  endtask

  task automatic do_write(input logic [3:0] typ, input logic [2:0] sel, input logic [7:0] wa,
                          input logic [7:0] d, input string tag);
    logic a, hit, acc, apply;
    hit   = (typ == 4'b1010) && (sel == SEL);
    acc   = hit && !(wa == 8'hFF && !exp_wel);
    apply = hit && wa == 8'hFF && exp_wel;
    bus_start();
    send_bits({typ, sel, 1'b0}, 8, 1'b0, 2'b00); get_ack(a);
    chk(a == hit, {tag, " address ack"}, a, hit);
    send_bits(wa, 8, 1'b0, 2'b00); get_ack(a);
    chk(a == hit, {tag, " word ack"}, a, hit);
    send_bits(d, 8, apply, d[1:0]); get_ack(a);
    chk(a == acc, {tag, " data ack"}, a, acc);
    if (hit && wa == 8'h00) begin
      if (d == 8'h01) exp_wel = 1'b1;
      else if (d == 8'h00) exp_wel = 1'b0;
    end
    bus_stop();
  endtask

  task automatic do_read(input logic [7:0] wa, input logic [7:0] exp, input string tag);
    logic a;
    logic [7:0] b;
    bus_start();
    send_bits({4'b1010, SEL, 1'b0}, 8, 1'b0, 2'b00); get_ack(a);
    chk(a, {tag, " read address ack"}, a, 1);
    send_bits(wa, 8, 1'b0, 2'b00); get_ack(a);
    chk(a, {tag, " read word ack"}, a, 1);
    bus_start();
    send_bits({4'b1010, SEL, 1'b1}, 8, 1'b0, 2'b00); get_ack(a);
    chk(a, {tag, " read select ack"}, a, 1);
    recv_byte(b);
    bus_stop();
    chk(b == exp, {tag, " read data"}, b, exp);
    chk(sda_oe == 1'b0, "R7 SDA released after read", sda_oe, 0);
  endtask

  initial begin
    logic a;
    tick(4);
    chk(shut_mode == 2'b00, "R1 reset shut_mode", shut_mode, 0);
    chk(sda_oe == 1'b0, "R1 reset sda_oe", sda_oe, 0);
    rst_n = 1'b1;
    tick(HALF);

    do_read(8'h00, 8'h0A, "R1 R3 status after reset");
    do_read(8'hFF, 8'h00, "R1 shutdown after reset");

    do_write(4'b1010, SEL, 8'hFF, 8'h03, "R5 locked write");
    do_read(8'hFF, 8'h00, "R5 locked value");

    do_write(4'b1010, SEL, 8'h00, 8'h03, "R4 odd value");
    do_read(8'h00, 8'h0A, "R4 latch still clear");

    do_write(4'b1010, SEL, 8'h00, 8'h01, "R4 set latch");
    gate_stat = 3'b010;
    do_read(8'h00, 8'h05, "R3 R4 status with latch");

    do_write(4'b1010, SEL, 8'hFF, 8'hFE, "R6 unlocked write");
    do_read(8'hFF, 8'h02, "R6 readback");

    do_write(4'b1010, 3'b011, 8'hFF, 8'h01, "R2 wrong select");
    do_write(4'b1011, SEL, 8'hFF, 8'h01, "R2 wrong type");
    do_read(8'hFF, 8'h02, "R2 no effect");

    do_write(4'b1010, SEL, 8'h40, 8'h55, "R8 other address write");
    do_read(8'h40, 8'h00, "R8 other address read");
    do_read(8'hFF, 8'h02, "R8 no effect on shutdown");

    bus_start();
    send_bits({4'b1010, SEL, 1'b0}, 8, 1'b0, 2'b00); get_ack(a);
    send_bits(8'hFF, 8, 1'b0, 2'b00); get_ack(a);
    send_bits(8'h01, 4, 1'b0, 2'b00);
    do_read(8'hFF, 8'h02, "R9 start aborts byte");

    bus_start();
    send_bits({4'b1010, SEL, 1'b0}, 8, 1'b0, 2'b00); get_ack(a);
    send_bits(8'hFF, 8, 1'b0, 2'b00); get_ack(a);
    send_bits(8'h01, 5, 1'b0, 2'b00);
    bus_stop();
    do_read(8'hFF, 8'h02, "R9 stop aborts byte");

    do_write(4'b1010, SEL, 8'h00, 8'h00, "R4 clear latch");
    do_write(4'b1010, SEL, 8'hFF, 8'h01, "R5 relocked write");
    do_read(8'hFF, 8'h02, "R5 relocked value");

    do_write(4'b1010, SEL, 8'h00, 8'h01, "R4 set again");
    do_write(4'b1010, SEL, 8'hFF, 8'h01, "R6 second write");
    do_read(8'hFF, 8'h01, "R6 R7 second readback");
    do_read(8'h00, 8'h05, "R7 status readback");

    chk(r10_viol == 0, "R10 SDA drive change while SCL high", r10_viol, 0);

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule